// File: doc/BRIEF.md
# System-Control Exception Controller

This block holds the three system-control registers of a 32-bit MIPS-style core: the status word, the cause word and the exception return address. When the pipeline signals a fault, the block does all of the exception entry in one clock cycle. It saves a record of the fault, pushes the privilege and interrupt-enable history one level deeper, and sends a one-cycle redirect strobe that carries the handler address to the program-counter logic.

Software reaches the registers through a move-from port with a registered read and a move-to port. A return-from-exception request pops the privilege history back one level. The core sends a fault code, the address of the faulting instruction and a flag that marks whether that instruction sat in a branch delay slot. The block adjusts the saved address so that the handler can restart the branch itself. Interrupt sources and address translation belong to other blocks.

Top module: `cp0_exc_ctrl`

## Requirements
- R1: Synchronous reset clears the status, cause and return-address registers, the read data and the redirect outputs to zero.
- R2: An exception request raises `redirect_valid` for exactly one cycle, on the edge that samples the request. `redirect_pc` is 0xBFC00180 when status bit 22 is 1 and 0x80000080 when it is 0.
- R3: On exception entry, status bits [5:0] become the old bits [3:0] followed by two zero bits. Status bits [31:6] keep their values.
- R4: On exception entry, the cause register takes the 5-bit fault code in bits [6:2], the delay-slot flag in bit 31, and zero in every other bit. The fault codes are syscall 0x8, load address error 0x4, store address error 0x5 and overflow 0xC.
- R5: On exception entry, the return-address register takes the faulting address. When the delay-slot flag is set it takes that address minus 4, modulo 2^32.
- R6: A return request whose function field (6 bits) equals 0x10 sets status bits [5:0] to two zero bits followed by the old bits [5:2], and leaves bits [31:6] unchanged. A return request with any other function value leaves status unchanged.
- R7: A move-to with register index 12 replaces all 32 status bits. A move-to with index 13 (cause) or 14 (return address) has no effect.
- R8: `mf_data` shows, one cycle after `mf_sel` is applied, status for index 12, cause for 13 and the return address for 14. It shows the value held before any update on that same edge. Every other index reads as zero.
- R9: When an exception request falls in the same cycle as a return request or a move-to, only the exception takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Fault code |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a delay slot |
| rfe_en | input | 1 | Return-from-exception request |
| rfe_funct | input | 6 | Low six bits of the return instruction |
| mt_en | input | 1 | Move-to request |
| mt_sel | input | 5 | Move-to register index |
| mt_data | input | 32 | Move-to write data |
| mf_sel | input | 5 | Move-from register index |
| mf_data | output | 32 | Registered move-from data |
| status_o | output | 32 | Current status word |
| redirect_valid | output | 1 | One-cycle handler redirect strobe |
| redirect_pc | output | 32 | Handler address |

## Verification
Exception entry can share a cycle with a software write to status or with a return-from-exception, and both of those also rewrite the status word. The bench first loads a known status value. It then raises an exception together with a move-to that carries a very different value, and later together with a valid return request. The status read back after each case must equal the pushed form of the value loaded before, which shows that the competing operation was dropped.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int XLEN      = 32;
  localparam int SEL_W     = 5;
  localparam int CODE_W    = 5;
  localparam int FN_W      = 6;
  localparam int STACK_W   = 6;

  localparam logic [SEL_W-1:0] IDX_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] IDX_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] IDX_EPC    = 5'd14;

  typedef enum logic [CODE_W-1:0] {
    EXC_LOAD_ADDR  = 5'h04,
    EXC_STORE_ADDR = 5'h05,
    EXC_SYSCALL    = 5'h08,
    EXC_OVERFLOW   = 5'h0C
  } exc_code_e;
endpackage

// File: rtl/cp0_mode_stack.sv
module cp0_mode_stack #(
  parameter int W     = 6,
  parameter int LEVEL = 2
) (
  input  logic [W-1:0] cur,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] nxt
);
  localparam int KEEP = W - LEVEL;

  generate
    if (KEEP > 0) begin : g_shift
      always_comb begin
        if (push)     nxt = {cur[KEEP-1:0], {LEVEL{1'b0}}};
        else if (pop) nxt = {{LEVEL{1'b0}}, cur[W-1:LEVEL]};
        else          nxt = cur;
      end
    end else begin : g_flat
      always_comb nxt = (push || pop) ? '0 : cur;
    end
  endgenerate
endmodule

// File: rtl/cp0_vec_sel.sv
module cp0_vec_sel #(
  parameter int          XLEN     = 32,
  parameter int          BOOT_BIT = 22,
  parameter logic [31:0] VEC_BOOT = 32'hBFC0_0180,
  parameter logic [31:0] VEC_MAIN = 32'h8000_0080
) (
  input  logic [XLEN-1:0] status,
  output logic [XLEN-1:0] vector
);
  always_comb vector = status[BOOT_BIT] ? XLEN'(VEC_BOOT) : XLEN'(VEC_MAIN);
endmodule

// File: rtl/cp0_read_port.sv
module cp0_read_port #(
  parameter int XLEN  = 32,
  parameter int SEL_W = 5,
  parameter int NREG  = 3,
  parameter logic [SEL_W*NREG-1:0] IDX = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     sel,
  input  logic [XLEN*NREG-1:0] regs,
  output logic [XLEN-1:0]      rdata
);
  logic [NREG-1:0]      hit;
  logic [XLEN-1:0]      picked;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_hit
      assign hit[g] = (sel == IDX[g*SEL_W +: SEL_W]);
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int k = 0; k < NREG; k++)
      if (hit[k]) picked = regs[k*XLEN +: XLEN];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= picked;
  end
endmodule

// File: rtl/cp0_exc_ctrl.sv
module cp0_exc_ctrl
  import cp0_pkg::*;
#(
  parameter int          DATA_W   = XLEN,
  parameter int          STK_W    = STACK_W,
  parameter int          BOOT_BIT = 22,
  parameter logic [31:0] VEC_BOOT = 32'hBFC0_0180,
  parameter logic [31:0] VEC_MAIN = 32'h8000_0080,
  parameter logic [5:0]  RFE_FN   = 6'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [DATA_W-1:0] exc_pc,
  input  logic              exc_in_delay,
  input  logic              rfe_en,
  input  logic [FN_W-1:0]   rfe_funct,
  input  logic              mt_en,
  input  logic [SEL_W-1:0]  mt_sel,
  input  logic [DATA_W-1:0] mt_data,
  input  logic [SEL_W-1:0]  mf_sel,
  output logic [DATA_W-1:0] mf_data,
  output logic [DATA_W-1:0] status_o,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc
);
  localparam int INSN_W = 4;

  logic [DATA_W-1:0] status_q, cause_q, epc_q;
  logic [DATA_W-1:0] vector;
  logic [STK_W-1:0]  stack_nxt;
  logic [DATA_W-1:0] cause_nxt, epc_nxt;
  logic              rfe_hit, mt_status;

  assign rfe_hit   = rfe_en && (rfe_funct == RFE_FN);
  assign mt_status = mt_en && (mt_sel == IDX_STATUS);

  cp0_mode_stack #(.W(STK_W), .LEVEL(2)) u_stack (
    .cur  (status_q[STK_W-1:0]),
    .push (exc_req),
    .pop  (rfe_hit && !exc_req),
    .nxt  (stack_nxt)
  );

  cp0_vec_sel #(
    .XLEN(DATA_W), .BOOT_BIT(BOOT_BIT), .VEC_BOOT(VEC_BOOT), .VEC_MAIN(VEC_MAIN)
  ) u_vec (
    .status (status_q),
    .vector (vector)
  );

  always_comb begin
    cause_nxt                  = '0;
    cause_nxt[CODE_W+1:2]      = exc_code;
    cause_nxt[DATA_W-1]        = exc_in_delay;
    epc_nxt = exc_in_delay ? (exc_pc - DATA_W'(INSN_W)) : exc_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q       <= '0;
      cause_q        <= '0;
      epc_q          <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else if (exc_req) begin
      status_q       <= {status_q[DATA_W-1:STK_W], stack_nxt};
      cause_q        <= cause_nxt;
      epc_q          <= epc_nxt;
      redirect_valid <= 1'b1;
      redirect_pc    <= vector;
    end else begin
      redirect_valid <= 1'b0;
      if (rfe_hit)        status_q <= {status_q[DATA_W-1:STK_W], stack_nxt};
      else if (mt_status) status_q <= mt_data;
    end
  end

  assign status_o = status_q;

  cp0_read_port #(
    .XLEN(DATA_W), .SEL_W(SEL_W), .NREG(3),
    .IDX({IDX_EPC, IDX_CAUSE, IDX_STATUS})
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (mf_sel),
    .regs  ({epc_q, cause_q, status_q}),
    .rdata (mf_data)
  );
endmodule

// File: rtl/cp0_exc_ctrl_chk.sv
module cp0_exc_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        exc_req,
  input logic [4:0]  exc_code,
  input logic [31:0] exc_pc,
  input logic        exc_in_delay,
  input logic        rfe_en,
  input logic [5:0]  rfe_funct,
  input logic        mt_en,
  input logic [4:0]  mt_sel,
  input logic [31:0] status_o,
  input logic [31:0] cause_q,
  input logic [31:0] epc_q,
  input logic        redirect_valid,
  input logic [31:0] redirect_pc
);
  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> redirect_valid);
  p_strobe_src_r2: assert property (@(posedge clk) disable iff (rst)
    !exc_req |=> !redirect_valid);
  p_vector_r2: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> redirect_pc == ($past(status_o[22]) ? 32'hBFC0_0180 : 32'h8000_0080));
  p_push_r3: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (status_o[5:0] == {$past(status_o[3:0]), 2'b00}) &&
                (status_o[31:6] == $past(status_o[31:6])));
  p_cause_r4: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> cause_q == {$past(exc_in_delay), 24'd0, $past(exc_code), 2'b00});
  p_epc_r5: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> epc_q == ($past(exc_in_delay) ? $past(exc_pc) - 32'd4 : $past(exc_pc)));
  p_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (rfe_en && rfe_funct == 6'h10 && !exc_req) |=>
      (status_o[5:0] == {2'b00, $past(status_o[5:2])}) &&
      (status_o[31:6] == $past(status_o[31:6])));
  p_bad_rfe_r6: assert property (@(posedge clk) disable iff (rst)
    (rfe_en && rfe_funct != 6'h10 && !exc_req && !(mt_en && mt_sel == 5'd12))
      |=> $stable(status_o));
  p_ro_regs_r7: assert property (@(posedge clk) disable iff (rst)
    !exc_req |=> $stable(cause_q) && $stable(epc_q));
endmodule

bind cp0_exc_ctrl cp0_exc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
  .exc_in_delay(exc_in_delay), .rfe_en(rfe_en), .rfe_funct(rfe_funct),
  .mt_en(mt_en), .mt_sel(mt_sel), .status_o(status_o), .cause_q(cause_q),
  .epc_q(epc_q), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/tb_cp0_exc_ctrl.sv
module tb_cp0_exc_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        exc_req, exc_in_delay, rfe_en, mt_en;
  logic [4:0]  exc_code, mt_sel, mf_sel;
  logic [31:0] exc_pc, mt_data;
  logic [5:0]  rfe_funct;
  logic [31:0] mf_data, status_o, redirect_pc;
  logic        redirect_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cp0_exc_ctrl dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
    .exc_in_delay(exc_in_delay), .rfe_en(rfe_en), .rfe_funct(rfe_funct),
    .mt_en(mt_en), .mt_sel(mt_sel), .mt_data(mt_data), .mf_sel(mf_sel),
    .mf_data(mf_data), .status_o(status_o), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  typedef struct packed {
    logic [31:0] st_init;
    logic [4:0]  code;
    logic [31:0] pc;
    logic        dly;
    logic [31:0] exp_st;
    logic [31:0] exp_cause;
    logic [31:0] exp_epc;
    logic [31:0] exp_vec;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t TABLE [NV] = '{
    '{32'h0040_0003, 5'h08, 32'h8000_1000, 1'b0, 32'h0040_000C, 32'h0000_0020, 32'h8000_1000, 32'hBFC0_0180},
    '{32'h0000_002D, 5'h04, 32'h8000_2004, 1'b1, 32'h0000_0034, 32'h8000_0010, 32'h8000_2000, 32'h8000_0080},
    '{32'hFFFF_FFFF, 5'h05, 32'h0000_0000, 1'b1, 32'hFFFF_FFFC, 32'h8000_0014, 32'hFFFF_FFFC, 32'hBFC0_0180},
    '{32'h1234_5601, 5'h0C, 32'hBFC0_0010, 1'b0, 32'h1234_5604, 32'h0000_0030, 32'hBFC0_0010, 32'h8000_0080}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    exc_req = 0; exc_in_delay = 0; exc_code = 0; exc_pc = 0;
    rfe_en = 0; rfe_funct = 0; mt_en = 0; mt_sel = 0; mt_data = 0;
  endtask

  task automatic write_status(input logic [31:0] v);
    mt_en = 1; mt_sel = 5'd12; mt_data = v;
    tick();
    idle();
  endtask

  task automatic read_reg(input logic [4:0] idx, output logic [31:0] v);
    mf_sel = idx;
    tick();
    v = mf_data;
  endtask

  initial begin
    logic [31:0] rv;
    idle();
    mf_sel = 5'd12;
    rst = 1;
    tick(); tick();
    // R1: reset state
    check("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
    check("R1 redirect_pc", redirect_pc, 32'd0);
    rst = 0;
    read_reg(5'd12, rv); check("R1 status", rv, 32'd0);
    read_reg(5'd13, rv); check("R1 cause", rv, 32'd0);
    read_reg(5'd14, rv); check("R1 epc", rv, 32'd0);

    for (int i = 0; i < NV; i++) begin
      write_status(TABLE[i].st_init);
      exc_req = 1; exc_code = TABLE[i].code; exc_pc = TABLE[i].pc;
      exc_in_delay = TABLE[i].dly;
      tick();
      idle();
      check("R2 strobe high", {31'd0, redirect_valid}, 32'd1);
      check("R2 vector", redirect_pc, TABLE[i].exp_vec);
      read_reg(5'd12, rv);
      check("R2 strobe one cycle", {31'd0, redirect_valid}, 32'd0);
      check("R3 status push", rv, TABLE[i].exp_st);
      read_reg(5'd13, rv); check("R4 cause", rv, TABLE[i].exp_cause);
      read_reg(5'd14, rv); check("R5 epc", rv, TABLE[i].exp_epc);
    end

    // R6: valid return pops
    write_status(32'hA500_003C);
    rfe_en = 1; rfe_funct = 6'h10; tick(); idle();
    read_reg(5'd12, rv); check("R6 pop", rv, 32'hA500_000F);
    // R6: wrong function field ignored
    rfe_en = 1; rfe_funct = 6'h11; tick(); idle();
    read_reg(5'd12, rv); check("R6 bad funct ignored", rv, 32'hA500_000F);
    rfe_en = 1; rfe_funct = 6'h30; tick(); idle();
    read_reg(5'd12, rv); check("R6 bad funct 0x30 ignored", rv, 32'hA500_000F);

    // R7: writes to cause and return address have no effect
    read_reg(5'd13, rv);
    mt_en = 1; mt_sel = 5'd13; mt_data = 32'hDEAD_BEEF; tick(); idle();
    read_reg(5'd13, rv); check("R7 cause read-only", rv, 32'h0000_0030);
    mt_en = 1; mt_sel = 5'd14; mt_data = 32'hDEAD_BEEF; tick(); idle();
    read_reg(5'd14, rv); check("R7 epc read-only", rv, 32'hBFC0_0010);
    read_reg(5'd12, rv); check("R7 status untouched", rv, 32'hA500_000F);

    // R8: unmapped index and read-before-update
    read_reg(5'd11, rv); check("R8 unmapped 11", rv, 32'd0);
    read_reg(5'd15, rv); check("R8 unmapped 15", rv, 32'd0);
    mf_sel = 5'd12; mt_en = 1; mt_sel = 5'd12; mt_data = 32'h0000_0001;
    tick(); idle();
    check("R8 old value on same edge", mf_data, 32'hA500_000F);
    tick();
    check("R8 new value next", mf_data, 32'h0000_0001);

    // R9: exception wins over move-to
    write_status(32'h0000_0005);
    exc_req = 1; exc_code = 5'h08; exc_pc = 32'h8000_0100;
    mt_en = 1; mt_sel = 5'd12; mt_data = 32'hFFFF_FFFF;
    tick(); idle();
    read_reg(5'd12, rv); check("R9 exc over move-to", rv, 32'h0000_0014);
    // R9: exception wins over return
    write_status(32'h0040_0030);
    exc_req = 1; exc_code = 5'h0C; exc_pc = 32'h8000_0200; exc_in_delay = 1;
    rfe_en = 1; rfe_funct = 6'h10;
    tick(); idle();
    check("R9 vector with return pending", redirect_pc, 32'hBFC0_0180);
    read_reg(5'd12, rv); check("R9 exc over return", rv, 32'h0040_0000);
    read_reg(5'd14, rv); check("R9 epc", rv, 32'h8000_01FC);

    // R1: reset again after activity
    rst = 1; tick(); rst = 0;
    check("R1 status after reset", status_o, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule